// File: doc/BRIEF.md
# Burst Flash Read Sequencer

This block is the device-side control of a synchronous burst-read memory. A host first writes a configuration word that holds a 3-bit latency code and a 2-bit burst mode. It then opens a read by pulsing an address-valid strobe while chip enable is high, which loads the start address. After the programmed number of clock cycles the block returns one word per clock, with a ready flag, until chip enable drops or a new strobe restarts it.

The storage array sits outside the block. It is a synchronous lookup: `mem_rdata` carries the word at the `mem_addr` value of the previous cycle. The block drives `mem_addr` and passes `mem_rdata` straight to `rd_data`. The word address either counts up linearly, rolling over from the top address to zero, or wraps inside an aligned group of 8, 16 or 32 words.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `rd_ready` is low, the latency is 7 cycles (code 101) and the burst mode is continuous (mode 00).
- R2: Latency codes 000, 001, 010, 011, 100 and 101 give latencies L of 2, 3, 4, 5, 6 and 7. If the strobe is sampled at clock edge k, the first word is valid with `rd_ready` high after edge k+L.
- R3: The reserved latency codes 110 and 111 behave as 7 cycles.
- R4: Each configuration write reloads the latency, including a write of the default code 101 after some other code.
- R5: `rd_ready` is low from the strobe until the first word. It then stays high, with one new word on `rd_data` per clock, while chip enable stays high. With latency 2 it rises together with the first word.
- R6: In mode 00 (continuous), each word address is the previous one plus one. After address 2^AW-1 the next address is 0.
- R7: Modes 01, 10 and 11 wrap in groups of 8, 16 and 32 words. The address counts up to the end of the aligned group, returns to the first word of that group and continues. It never leaves the 64-word aligned block that holds the start address.
- R8: When chip enable is low at a clock edge, `rd_ready` is low after that edge and the burst ends. A strobe sampled while chip enable is low is ignored, and `mem_addr` holds its value.
- R9: A strobe sampled during a burst aborts it. The block restarts from the new address with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_lat_code | input | 3 | Latency code |
| cfg_mode | input | 2 | Burst mode: 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| chip_en | input | 1 | Chip enable, active high |
| addr_valid | input | 1 | Address-valid strobe |
| start_addr | input | AW | Burst start word address |
| mem_addr | output | AW | Word address to the array |
| mem_rdata | input | DW | Array word, one cycle after `mem_addr` |
| rd_data | output | DW | Burst data to the host |
| rd_ready | output | 1 | Burst word valid |

## Verification
The address-order properties assume that the burst mode does not change while a burst runs. The stimulus therefore writes the configuration only after chip enable has been dropped and the ready flag has returned low. The properties also assume that the array answers in exactly one cycle, which the bench's lookup model provides. Strobes are single-cycle pulses, and a restart is issued only at a sampled edge while chip enable is held high.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   typedef enum logic [1:0] {
      BM_CONT   = 2'b00,
      BM_WRAP8  = 2'b01,
      BM_WRAP16 = 2'b10,
      BM_WRAP32 = 2'b11
   } burst_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_WAIT  = 2'b01,
      ST_BURST = 2'b10
   } seq_state_e;

   localparam int          LAT_CODE_W     = 3;
   localparam logic [2:0]  LAT_CODE_RESET = 3'b101;
   localparam int          LAT_MIN        = 2;
   localparam int          LAT_MAX_CODE   = 5;
   localparam int          WRAP_LOG_MIN   = 3;
   localparam int          NUM_WRAP       = 3;
   localparam int          BLOCK_LOG      = 6;
endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
   import bseq_pkg::*;
#(
   parameter int CODE_W   = LAT_CODE_W,
   parameter int CNT_W    = 3,
   parameter int MIN_LAT  = LAT_MIN,
   parameter int MAX_CODE = LAT_MAX_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CODE_W-1:0] lat_code_in,
   input  logic [1:0]        mode_in,
   output logic [CNT_W-1:0]  lat_cycles,
   output burst_mode_e       mode_q
);
   localparam int TOP_LAT = MAX_CODE + MIN_LAT;

   if (TOP_LAT >= (1 << CNT_W)) begin : g_bad_cnt
      $error("bseq_cfg: CNT_W too narrow for the largest latency");
   end
   if (MIN_LAT < 2) begin : g_bad_min
      $error("bseq_cfg: latency below 2 cycles is not supported");
   end

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_W'(LAT_CODE_RESET);
         mode_q <= BM_CONT;
      end else if (we) begin
         code_q <= lat_code_in;
         mode_q <= burst_mode_e'(mode_in);
      end
   end

   always_comb begin
      if (int'(code_q) > MAX_CODE)
         lat_cycles = CNT_W'(TOP_LAT);
      else
         lat_cycles = CNT_W'(int'(code_q) + MIN_LAT);
   end
endmodule

// File: rtl/bseq_timer.sv
module bseq_timer
   import bseq_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             strobe,
   input  logic [CNT_W-1:0] lat_cycles,
   output logic             step,
   output logic             ready
);
   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_wait;

   assign last_wait = (state_q == ST_WAIT) && (cnt_q == lat_cycles - CNT_W'(1));
   assign step      = enable && !strobe && (last_wait || state_q == ST_BURST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ready   <= 1'b0;
      end else if (!enable) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ready   <= 1'b0;
      end else if (strobe) begin
         state_q <= ST_WAIT;
         cnt_q   <= '0;
         ready   <= 1'b0;
      end else begin
         case (state_q)
            ST_WAIT: begin
               if (last_wait) begin
                  state_q <= ST_BURST;
                  ready   <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_BURST: ready <= 1'b1;
            default: begin
               state_q <= ST_IDLE;
               ready   <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
   import bseq_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          step,
   input  burst_mode_e   mode,
   output logic [AW-1:0] addr_q
);
   if (AW < BLOCK_LOG) begin : g_bad_aw
      $error("bseq_addr_gen: AW must cover at least one 64-word block");
   end

   logic [AW-1:0] wrap_nx [NUM_WRAP];
   logic [AW-1:0] next_addr;

   for (genvar g = 0; g < NUM_WRAP; g++) begin : g_wrap
      localparam int GB = WRAP_LOG_MIN + g;
      logic [GB-1:0] low_inc;
      assign low_inc    = addr_q[GB-1:0] + GB'(1);
      assign wrap_nx[g] = {addr_q[AW-1:GB], low_inc};
   end

   always_comb begin
      case (mode)
         BM_WRAP8:  next_addr = wrap_nx[0];
         BM_WRAP16: next_addr = wrap_nx[1];
         BM_WRAP32: next_addr = wrap_nx[2];
         default:   next_addr = addr_q + AW'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= load_addr;
      else if (step) addr_q <= next_addr;
   end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
   import bseq_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [LAT_CODE_W-1:0] cfg_lat_code,
   input  logic [1:0]            cfg_mode,
   input  logic                  chip_en,
   input  logic                  addr_valid,
   input  logic [AW-1:0]         start_addr,
   output logic [AW-1:0]         mem_addr,
   input  logic [DW-1:0]         mem_rdata,
   output logic [DW-1:0]         rd_data,
   output logic                  rd_ready
);
   localparam int CNT_W = $clog2(LAT_MAX_CODE + LAT_MIN + 1);

   if (DW < 1) begin : g_bad_dw
      $error("burst_read_seq: DW must be positive");
   end

   logic             strobe_ok;
   logic             step;
   logic [CNT_W-1:0] lat_cycles;
   burst_mode_e      mode_q;

   assign strobe_ok = chip_en && addr_valid;
   assign rd_data   = mem_rdata;

   bseq_cfg #(.CNT_W(CNT_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (cfg_we),
      .lat_code_in (cfg_lat_code),
      .mode_in     (cfg_mode),
      .lat_cycles  (lat_cycles),
      .mode_q      (mode_q)
   );

   bseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (chip_en),
      .strobe     (strobe_ok),
      .lat_cycles (lat_cycles),
      .step       (step),
      .ready      (rd_ready)
   );

   bseq_addr_gen #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (strobe_ok),
      .load_addr (start_addr),
      .step      (step),
      .mode      (mode_q),
      .addr_q    (mem_addr)
   );
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          chip_en,
   input logic          addr_valid,
   input logic [AW-1:0] start_addr,
   input logic [AW-1:0] mem_addr,
   input logic          rd_ready,
   input logic [1:0]    mode_q
);
   AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en && addr_valid |=> !rd_ready && mem_addr == $past(start_addr)); // R9

   AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> !rd_ready); // R8

   AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> mem_addr == $past(mem_addr)); // R8

   AST_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_ready) |-> !$past(chip_en && addr_valid)); // R5

   AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready && $past(rd_ready) && mode_q == 2'b00 |-> mem_addr == $past(mem_addr) + AW'(1)); // R6

   AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready && $past(rd_ready) && mode_q != 2'b00 |-> mem_addr[AW-1:6] == $past(mem_addr[AW-1:6])); // R7
endmodule

bind burst_read_seq bseq_checker #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_en    (chip_en),
   .addr_valid (addr_valid),
   .start_addr (start_addr),
   .mem_addr   (mem_addr),
   .rd_ready   (rd_ready),
   .mode_q     (mode_q)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;
   localparam int AW    = 10;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_lat_code = '0;
   logic [1:0]    cfg_mode = '0;
   logic          chip_en = 1'b0;
   logic          addr_valid = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_ready;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   burst_read_seq #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lat_code(cfg_lat_code),
      .cfg_mode(cfg_mode), .chip_en(chip_en), .addr_valid(addr_valid),
      .start_addr(start_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .rd_data(rd_data), .rd_ready(rd_ready)
   );

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return DW'(int'(a) * 37 + 11);
   endfunction

   always_ff @(posedge clk) mem_rdata <= word_of(mem_addr);

   function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a, input int mode);
      int n, ai;
      ai = int'(a);
      if (mode == 0) return AW'((ai + 1) % DEPTH);
      n = 4 << mode;
      return AW'(ai - (ai % n) + ((ai % n) + 1) % n);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input int code, input int mode);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lat_code = 3'(code); cfg_mode = 2'(mode);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_burst(input logic [AW-1:0] start, input int nwords,
                            input int lat, input int mode, input string tag);
      int bad = 0;
      int act = 0;
      int exp = 0;
      logic [AW-1:0] a;
      @(negedge clk);
      chip_en = 1'b1; addr_valid = 1'b1; start_addr = start;
      @(negedge clk);
      addr_valid = 1'b0;
      if (rd_ready) begin bad++; act = 1; exp = 0; end
      for (int j = 1; j < lat; j++) begin
         @(negedge clk);
         if (rd_ready && bad == 0) begin act = 1; exp = 0; end
         if (rd_ready) bad++;
      end
      a = start;
      for (int w = 0; w < nwords; w++) begin
         @(negedge clk);
         if (!rd_ready || rd_data !== word_of(a)) begin
            if (bad == 0) begin
               act = rd_ready ? int'(rd_data) : -1;
               exp = int'(word_of(a));
            end
            bad++;
         end
         a = ref_next(a, mode);
      end
      chk(bad == 0, tag, act, exp);
   endtask

   task automatic end_burst(input string tag);
      @(negedge clk);
      chip_en = 1'b0;
      @(negedge clk);
      chk(rd_ready == 1'b0, tag, int'(rd_ready), 0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_ready == 1'b0, "R1 ready low in reset", int'(rd_ready), 0);
      rst_n = 1'b1;
      run_burst(AW'(16), 5, 7, 0, "R1 default 7 cycles continuous");
      end_burst("R8 burst ends after reset test");
   endtask

   task automatic t_latency;
      for (int c = 0; c <= 5; c++) begin
         write_cfg(c, 0);
         run_burst(AW'(100 + c * 5), 6, c + 2, 0, "R2/R5 latency code");
         end_burst("R8 end after latency test");
      end
   endtask

   task automatic t_reserved;
      for (int c = 6; c <= 7; c++) begin
         write_cfg(c, 0);
         run_burst(AW'(200 + c), 4, 7, 0, "R3 reserved code as 7");
         end_burst("R8 end after reserved test");
      end
   endtask

   task automatic t_rewrite;
      write_cfg(0, 0);
      run_burst(AW'(300), 3, 2, 0, "R4 code 000 gives 2");
      end_burst("R8 end after rewrite 1");
      write_cfg(5, 0);
      run_burst(AW'(310), 3, 7, 0, "R4 rewrite of default 101 gives 7");
      end_burst("R8 end after rewrite 2");
   endtask

   task automatic t_wrap;
      for (int m = 1; m <= 3; m++) begin
         int n;
         n = 4 << m;
         write_cfg(0, m);
         for (int off = 0; off < n; off++) begin
            run_burst(AW'(64 * 4 + 64 - n + off), n + 3, 2, m, "R7 wrap order");
            end_burst("R8 end after wrap");
         end
      end
   endtask

   task automatic t_rollover;
      write_cfg(1, 0);
      run_burst(AW'(DEPTH - 3), 8, 3, 0, "R6 continuous rolls to zero");
      end_burst("R8 end after rollover");
   endtask

   task automatic t_ce_ignore;
      logic [AW-1:0] held;
      int bad = 0;
      @(negedge clk);
      chip_en = 1'b0;
      held = mem_addr;
      addr_valid = 1'b1; start_addr = AW'(555);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (rd_ready || mem_addr !== held) bad++;
      end
      addr_valid = 1'b0;
      chk(bad == 0, "R8 strobe ignored with chip enable low", int'(mem_addr), int'(held));
   endtask

   task automatic t_restart;
      write_cfg(2, 0);
      run_burst(AW'(400), 4, 4, 0, "R9 first burst");
      run_burst(AW'(700), 6, 4, 0, "R9 restart from new address");
      end_burst("R8 end after restart");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_latency();
      t_reserved();
      t_rewrite();
      t_wrap();
      t_rollover();
      t_ce_ignore();
      t_restart();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule